// File: doc/BRIEF.md
# Cardiac Pacing Pulse Controller

This block decides, once per clock, whether the heart needs an artificial stimulus. It watches two inputs. `sense_i` is high when a natural contraction has been detected. `timer_i` is high once the expected interval between beats, about one second, has run out. When the interval expires and no contraction has been seen, the block raises `pace_o`. The timer that produces `timer_i` sits outside the block.

The block is a Mealy machine with a two-bit phase register on `clk`. It has four phases:

- `PH_START` (00): the rest point after reset or after a beat.
- `PH_ARMED` (01): waiting for either a contraction or the timer.
- `PH_SPARE` (10): an unused code that only leads back to `PH_START`.
- `PH_FIRED` (11): a one-cycle recovery phase entered after a stimulus.

The transitions are:

- **arm**: `PH_START` to `PH_ARMED`, whatever the inputs.
- **beat**: `PH_ARMED` to `PH_START` when a contraction is sensed.
- **wait**: `PH_ARMED` stays in `PH_ARMED` when neither input is high.
- **fire**: `PH_ARMED` to `PH_FIRED` when the timer expires with no contraction.
- **recover**: `PH_FIRED` to `PH_START`.
- **scrub**: `PH_SPARE` to `PH_START`.

`pace_o` is formed directly from the phase and the two inputs, with no register in between. It therefore follows `sense_i` between clock edges. The phase register is brought out on `phase_o` so that the surrounding logic can observe it.

Top module: `pacing_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the phase register loads the parameter `RESET_PHASE` (default 00); reset is synchronous and active high.
- R2: In phase 00 (`PH_START`), `pace_o` is 0 and the next phase is 01 for all four input combinations.
- R3: In phase 01 (`PH_ARMED`) with `sense_i`=1, `pace_o` is 0 and the next phase is 00, whatever `timer_i` is.
- R4: In phase 01 with `sense_i`=0 and `timer_i`=0, `pace_o` is 0 and the phase stays 01.
- R5: In phase 01 with `sense_i`=0 and `timer_i`=1, `pace_o` is 1 and the next phase is 11 (`PH_FIRED`).
- R6: In phase 11, `pace_o` is 0 and the next phase is 00 for all input combinations.
- R7: In phase 10 (`PH_SPARE`), `pace_o` is 0 and the next phase is 00 for all input combinations.
- R8: `pace_o` reacts to a change of `sense_i` within the same clock cycle, without waiting for a clock edge.
- R9: A missed contraction at timer expiry produces exactly one cycle with `pace_o`=1, followed by phase 11 and then phase 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the phase register |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | 1 | High when a contraction is detected |
| timer_i | input | 1 | High when the beat interval has expired |
| pace_o | output | 1 | Pacing stimulus, combinational |
| phase_o | output | 2 | Current phase code |

## Verification
The bench builds two copies of the block. One uses the default `RESET_PHASE` of 00. The other uses 10, because the unused phase cannot be reached from a normal reset, and this copy lets its scrub transition be tested under all four input pairs. With both copies, every one of the sixteen phase-and-input combinations is checked against a behavioural model. A mid-cycle toggle of `sense_i` while the timer is expired shows that the stimulus output follows the sense input between clock edges.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    typedef enum logic [1:0] {
        PH_START = 2'b00,
        PH_ARMED = 2'b01,
        PH_SPARE = 2'b10,
        PH_FIRED = 2'b11
    } phase_t;
endpackage

// File: rtl/pacer_out.sv
module pacer_out
    import pacer_pkg::*;
(
    input  phase_t cur,
    input  logic   sense,
    input  logic   timer,
    output logic   pace
);
    // Mealy output: only the armed phase may fire, and only when no beat is seen
    always_comb begin
        pace = 1'b0;
        unique case (cur)
            PH_ARMED: pace = !sense && timer;
            PH_START,
            PH_SPARE,
            PH_FIRED: pace = 1'b0;
        endcase
    end
endmodule

// File: rtl/pacer_next.sv
module pacer_next
    import pacer_pkg::*;
(
    input  phase_t cur,
    input  logic   sense,
    input  logic   pace,
    output phase_t nxt
);
    always_comb begin
        nxt = PH_START;
        unique case (cur)
            PH_START: nxt = PH_ARMED;                   // arm
            PH_ARMED: begin
                if (sense)     nxt = PH_START;          // beat
                else if (pace) nxt = PH_FIRED;          // fire
                else           nxt = PH_ARMED;          // wait
            end
            PH_FIRED: nxt = PH_START;                   // recover
            PH_SPARE: nxt = PH_START;                   // scrub
        endcase
    end
endmodule

// File: rtl/pacing_ctrl.sv
module pacing_ctrl
    import pacer_pkg::*;
#(
    parameter logic [1:0] RESET_PHASE = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sense_i,
    input  logic       timer_i,
    output logic       pace_o,
    output logic [1:0] phase_o
);
    localparam phase_t RST_PH = phase_t'(RESET_PHASE);

    phase_t cur_q;
    phase_t nxt_c;
    logic   pace_c;

    pacer_out u_out (
        .cur   (cur_q),
        .sense (sense_i),
        .timer (timer_i),
        .pace  (pace_c)
    );

    pacer_next u_next (
        .cur   (cur_q),
        .sense (sense_i),
        .pace  (pace_c),
        .nxt   (nxt_c)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= RST_PH;
        else     cur_q <= nxt_c;
    end

    assign pace_o  = pace_c;
    assign phase_o = cur_q;

    assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
        cur_q == PH_START |=> cur_q == PH_ARMED);
    assert_beat_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_ARMED && sense_i) |=> cur_q == PH_START);
    assert_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_ARMED && !sense_i && !timer_i) |=> cur_q == PH_ARMED);
    assert_fire_R5: assert property (@(posedge clk) disable iff (rst)
        pace_o |=> cur_q == PH_FIRED);
    assert_recover_R6: assert property (@(posedge clk) disable iff (rst)
        cur_q == PH_FIRED |=> cur_q == PH_START);
    assert_scrub_R7: assert property (@(posedge clk) disable iff (rst)
        cur_q == PH_SPARE |=> cur_q == PH_START);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        pace_o |=> !pace_o);
endmodule

// File: tb/pacing_ctrl_test.sv
module pacing_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sense = 1'b0;
    logic timer = 1'b0;
    logic pa, pb;
    logic [1:0] pha, phb;
    int total = 0;
    int bad = 0;
    int ma = 0;
    int mb = 2;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    pacing_ctrl uut (
        .clk(clk), .rst(rst), .sense_i(sense), .timer_i(timer),
        .pace_o(pa), .phase_o(pha)
    );

    pacing_ctrl #(.RESET_PHASE(2'b10)) uut_spare (
        .clk(clk), .rst(rst), .sense_i(sense), .timer_i(timer),
        .pace_o(pb), .phase_o(phb)
    );

    function automatic int m_next(int st, logic s, logic t);
        case (st)
            0: return 1;
            1: if (s) return 0; else if (t) return 3; else return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic m_pace(int st, logic s, logic t);
        return (st == 1) && !s && t;
    endfunction

    function automatic string req_of(int st, logic s, logic t);
        case (st)
            0: return "R2";
            1: if (s) return "R3"; else if (t) return "R5"; else return "R4";
            2: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts and ends at a falling edge
    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ma = 0;
        mb = 2;
        chk(pha == 2'b00, "R1", pha, 0);
        chk(phb == 2'b10, "R1", phb, 2);
    endtask

    // one cycle: drive, check output and phase, advance the model
    task automatic step(input logic s, input logic t);
        int na, nb;
        sense = s;
        timer = t;
        #2;
        chk(pha == 2'(ma), req_of(ma, s, t), pha, ma);
        chk(pa == m_pace(ma, s, t), req_of(ma, s, t), pa, m_pace(ma, s, t));
        chk(phb == 2'(mb), req_of(mb, s, t), phb, mb);
        chk(pb == m_pace(mb, s, t), req_of(mb, s, t), pb, m_pace(mb, s, t));
        na = m_next(ma, s, t);
        nb = m_next(mb, s, t);
        @(posedge clk);
        ma = na;
        mb = nb;
        @(negedge clk);
        chk(pha == 2'(ma), "R1", pha, ma);
        chk(phb == 2'(mb), "R7", phb, mb);
    endtask

    initial begin
        int pulses;
        @(negedge clk);
        do_reset();

        // phases 00 and 10 under every input pair
        for (int c = 0; c < 4; c++) begin
            do_reset();
            step(c[1], c[0]);
        end
        // phase 01 under every input pair
        for (int c = 0; c < 4; c++) begin
            do_reset();
            step(1'b0, 1'b0);
            step(c[1], c[0]);
        end
        // phase 11 under every input pair
        for (int c = 0; c < 4; c++) begin
            do_reset();
            step(1'b0, 1'b0);
            step(1'b0, 1'b1);
            step(c[1], c[0]);
        end

        // R8: the output follows sense between edges
        do_reset();
        step(1'b0, 1'b0);
        sense = 1'b0;
        timer = 1'b1;
        #1;
        chk(pa == 1'b1, "R8", pa, 1);
        sense = 1'b1;
        #1;
        chk(pa == 1'b0, "R8", pa, 0);
        sense = 1'b0;
        #1;
        chk(pa == 1'b1, "R8", pa, 1);
        sense = 1'b1;
        #1;
        @(posedge clk);
        ma = 0;
        mb = 0;
        @(negedge clk);
        chk(pha == 2'b00, "R3", pha, 0);

        // R9: normal beats, then a missed beat at timer expiry
        do_reset();
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            step(1'b1, 1'b0);
        end
        step(1'b0, 1'b0);
        pulses = 0;
        for (int i = 0; i < 4; i++) begin
            sense = 1'b0;
            timer = (i >= 2);
            #2;
            if (pa) pulses++;
            @(posedge clk);
            @(negedge clk);
            if (i == 2) chk(pha == 2'b11, "R9", pha, 3);
            if (i == 3) chk(pha == 2'b00, "R9", pha, 0);
        end
        chk(pulses == 1, "R9", pulses, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule